// File: doc/BRIEF.md
# PLL Lock Qualification Gate

This block turns the raw lock indication of a PLL into a qualified lock that the rest of the chip can trust. A raw lock can flicker while the loop settles. The qualified output therefore stays low until the raw lock has been seen high without a break for a fixed run of reference clock cycles. The run length comes from a counter width parameter. Once qualified, the output follows the raw lock down at once, and every dropout starts the qualification again from zero.

The raw lock arrives from another timing domain. It passes through a two-flop synchronizer clocked by the counting clock. A saturating counter runs only while the synchronized lock is high, and it is cleared whenever that lock is low. The registered output is the AND of both synchronizer stages and the counter's terminal state. A drop therefore reaches the output one stage earlier than a rise.

Top module: `lock_qual_gate`

## Requirements
- R1: While `rst` is sampled high, the counter and synchronizer clear, and `gated_lock` is low after that edge.
- R2: Count the consecutive clock edges at which `raw_lock` is sampled high. `gated_lock` goes high on the edge after the count reaches 2^CNT_W + 1 (9 samples, so the rising edge is the 10th, for the default CNT_W = 3). It is not high earlier.
- R3: `gated_lock` is low after the edge that follows the first edge at which `raw_lock` is sampled low. This holds however long the lock had been qualified.
- R4: Any low sample of `raw_lock`, even one lasting a single cycle, restarts qualification. A fresh run of 2^CNT_W + 1 high samples is needed before `gated_lock` rises again.
- R5: The counter saturates at its terminal count and never wraps. `gated_lock` stays high for as long as `raw_lock` stays high.
- R6: A high run of `raw_lock` shorter than 2^CNT_W + 1 samples, including a steady toggle, never makes `gated_lock` high.
- R7: The qualification length follows CNT_W. With CNT_W = 2 the run is 5 samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting (reference) clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_lock | input | 1 | Unqualified lock indication from the PLL, asynchronous |
| gated_lock | output | 1 | Registered qualified lock |

## Verification
Each result depends on the raw lock samples up to the edge before the output changes. The qualified lock after edge n is high exactly when the last 2^CNT_W + 1 samples, ending at edge n-1, were all high. A rise is therefore due 2^CNT_W + 2 edges after the raw lock first rises, and a fall two edges after it first drops. The bench keeps a run-length integer that is updated at each rising edge after the expected value for that edge has been taken. It compares both instances (CNT_W = 3 and CNT_W = 2) on the falling edge, when the registered output has settled.

// File: rtl/lockq_pkg.sv
package lockq_pkg;
  // Terminal count of a saturating counter of the given width.
  function automatic int unsigned term_count(input int unsigned width);
    return (32'd1 << width) - 32'd1;
  endfunction
endpackage

// File: rtl/lockq_sync.sv
module lockq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic pre_out,   // stage before the last
  output logic sync_out   // last stage
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign pre_out  = chain_q[STAGES-2];
  assign sync_out = chain_q[STAGES-1];

  // R1: reset empties the chain
  a_r1_sync_clear: assert property (@(posedge clk) rst |=> (chain_q == '0));
endmodule

// File: rtl/lockq_counter.sv
module lockq_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] count,
  output logic             term
);
  import lockq_pkg::*;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(term_count(CNT_W));

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)        cnt_q <= '0;
    else if (cnt_q != MAX_CNT) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
  assign term  = (cnt_q == MAX_CNT);

  // R5: saturates at the terminal count without wrapping
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (term && run) |=> term);
  // R4: any low sample clears the count
  a_r4_clear_on_drop: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count == '0));
  // R2: count advances by exactly one while running below terminal
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (run && !term) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/lock_qual_gate.sv
module lock_qual_gate #(
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_lock,
  output logic gated_lock
);
  logic             lk_pre, lk_sync;
  logic [CNT_W-1:0] run_cnt;
  logic             run_term;
  logic             gated_q;

  lockq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .din      (raw_lock),
    .pre_out  (lk_pre),
    .sync_out (lk_sync)
  );

  lockq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (lk_sync),
    .count (run_cnt),
    .term  (run_term)
  );

  // Early stage in the AND lets a loss reach the output one stage sooner.
  always_ff @(posedge clk) begin
    if (rst) gated_q <= 1'b0;
    else     gated_q <= lk_pre & lk_sync & run_term;
  end

  assign gated_lock = gated_q;

  // R1: reset forces the output low
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !gated_lock);
  // R3: a low value entering the synchronizer drops the output next edge
  a_r3_fast_drop: assert property (@(posedge clk) disable iff (rst)
    !lk_pre |=> !gated_lock);
  // R2: a rise only follows a counter at its terminal value
  a_r2_rise_needs_term: assert property (@(posedge clk) disable iff (rst)
    $rose(gated_lock) |-> $past(run_term));
  // R6: output never high while the synchronized lock was low
  a_r6_no_early: assert property (@(posedge clk) disable iff (rst)
    !lk_sync |=> !gated_lock);
endmodule

// File: tb/test_lock_qual_gate.sv
`timescale 1ns/1ps
module test_lock_qual_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_lock = 1'b0;
  logic gl3, gl2;

  int checks = 0;
  int fails  = 0;
  string phase = "R1 reset";

  always #2 clk = ~clk;  // 250 MHz

  lock_qual_gate #(.CNT_W(3)) i_lock_qual_gate (
    .clk(clk), .rst(rst), .raw_lock(raw_lock), .gated_lock(gl3));
  lock_qual_gate #(.CNT_W(2)) i_lock_qual_gate_w2 (
    .clk(clk), .rst(rst), .raw_lock(raw_lock), .gated_lock(gl2));

  // Behavioural reference: run length of consecutive high samples.
  localparam int QUAL3 = (1 << 3) + 1;
  localparam int QUAL2 = (1 << 2) + 1;
  int  run_len = 0;
  logic exp3 = 1'b0, exp2 = 1'b0;
  logic started = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      exp3 = 1'b0; exp2 = 1'b0; run_len = 0;
    end else begin
      exp3 = (run_len >= QUAL3);
      exp2 = (run_len >= QUAL2);
      run_len = raw_lock ? run_len + 1 : 0;
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (gl3 !== exp3) begin
        fails++;
        $display("FAIL %s (CNT_W=3) t=%0t actual=%b expected=%b", phase, $time, gl3, exp3);
      end
      checks++;
      if (gl2 !== exp2) begin
        fails++;
        $display("FAIL %s R7 (CNT_W=2) t=%0t actual=%b expected=%b", phase, $time, gl2, exp2);
      end
    end
  end

  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      raw_lock = v;
      @(negedge clk);
    end
  endtask

  // Explicit point check of the R2 rise edge
  task automatic rise_check;
    int seen;
    seen = 0;
    drive(1'b0, 4);
    for (int i = 1; i <= 12; i++) begin
      raw_lock = 1'b1;
      @(negedge clk);
      if (gl3 === 1'b1 && seen == 0) seen = i;
    end
    checks++;
    if (seen != 10) begin
      fails++;
      $display("FAIL R2 rise edge actual=%0d expected=10", seen);
    end
  endtask

  initial begin : stim
    @(negedge clk);
    phase = "R1 reset";
    drive(1'b1, 5);             // raw high during reset: output must stay low
    rst = 1'b0;
    phase = "R2 qualify";
    drive(1'b1, 30);
    phase = "R5 hold";
    drive(1'b1, 100);
    phase = "R3 drop";
    drive(1'b0, 4);
    phase = "R2 rise edge";
    rise_check();
    phase = "R4 one-cycle dropout";
    drive(1'b0, 1);
    drive(1'b1, 15);
    phase = "R6 toggle";
    for (int i = 0; i < 20; i++) begin
      drive(1'b1, 1);
      drive(1'b0, 1);
    end
    phase = "R6 short runs";
    drive(1'b1, 8); drive(1'b0, 2);
    drive(1'b1, 4); drive(1'b0, 2);
    drive(1'b1, 9); drive(1'b0, 3);
    drive(1'b1, 10); drive(1'b0, 3);
    phase = "R4 repeated dropouts";
    for (int i = 0; i < 5; i++) begin
      drive(1'b1, 12);
      drive(1'b0, i + 1);
    end
    phase = "R1 reset while locked";
    drive(1'b1, 20);
    rst = 1'b1;
    drive(1'b1, 3);
    rst = 1'b0;
    phase = "R2 requalify after reset";
    drive(1'b1, 15);
    phase = "R3 final drop";
    drive(1'b0, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule